// File: doc/BRIEF.md
# Default Queue Setup Sequencer

After a master reset, this block fills the setup registers of a four-queue buffer with default values. It runs on the write clock. Each register takes one clock cycle. The defaults give the full number of queues, with the shared memory cut into equal, contiguous regions. The register outputs carry the queue count and the first and last word address of each queue. Downstream queue logic uses these values directly.

Completion is reported on an active-low serial-enable chain. A device loads only while its serial-enable input is low. When loading is finished, it drives its own serial-enable output low. That output feeds the next device's serial-enable input. A standalone device, or the first device in a chain, has its input tied low. The output of the last device going low means that every device in the chain is configured. A ready output rises in the same cycle, so that the write and read ports can be gated until configuration is valid.

The load order is fixed. The mode word comes first, at load step 0. Then come the start/end address pairs for queue 0 through queue NUM_QUEUES-1: the start at step 2q+1 and the end at step 2q+2. The total is 2*NUM_QUEUES+1 steps.

Top module: `qcfg_default_seq`

## Requirements
- R1: While `rst` is high, `sen_out` is 1, `cfg_ready` is 0, and `q_count`, every `q_start` entry and every `q_end` entry are 0. The reset is asynchronous.
- R2: After reset is released with `sen_in` held low, `sen_out` goes from 1 to 0 after exactly 2*NUM_QUEUES+1 rising clock edges. With the defaults this is 9 edges.
- R3: In a chain where one device's `sen_out` drives the next device's `sen_in`, the downstream device loads nothing while the upstream device is busy. A chain of two devices has its final `sen_out` fall after 2*(2*NUM_QUEUES+1) edges.
- R4: Once `sen_out` is low, `q_count` equals NUM_QUEUES.
- R5: Once `sen_out` is low, `q_start[q]` equals q*(MEM_DEPTH/NUM_QUEUES) and `q_end[q]` equals `q_start[q]`+MEM_DEPTH/NUM_QUEUES-1 for every queue q.
- R6: On a rising edge where `sen_in` is high, the load step does not advance, no setup output changes, and `sen_out` stays high.
- R7: A pause in `sen_in` during loading keeps the values already loaded, and loading resumes where it stopped. The total is still 2*NUM_QUEUES+1 edges with `sen_in` low. After 4 such edges, `q_start[1]` is loaded and `q_end[1]` is still 0.
- R8: After `sen_out` has gone low, it stays low and the setup outputs hold, whatever `sen_in` does, until the next reset.
- R9: `cfg_ready` is 1 exactly when `sen_out` is 0.
- R10: A reset in the middle of loading clears the partial values. The next load runs the full 2*NUM_QUEUES+1 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst | input | 1 | Master reset, active high, asynchronous |
| sen_in | input | 1 | Serial-enable from upstream, active low (tie low if first or alone) |
| sen_out | output | 1 | Serial-enable to downstream; low once this device is configured |
| cfg_ready | output | 1 | High once configuration is valid |
| q_count | output | QCNT_W (3) | Configured number of queues |
| q_start | output | NUM_QUEUES x ADDR_W (4x12) | First word address of each queue |
| q_end | output | NUM_QUEUES x ADDR_W (4x12) | Last word address of each queue |

## Verification
The assertions check on every cycle the properties that hold at any time:
- the idle outputs during reset;
- that `sen_out` falls only after an edge with `sen_in` low;
- that the outputs freeze on edges where `sen_in` is high;
- that the done state is permanent;
- the queue count and the size of each region once done.

Only the bench scenarios can show behaviour that depends on counting edges or on history:
- the exact cycle on which `sen_out` falls;
- the load order, seen through partial values during a pause;
- the restart after a reset in the middle of loading;
- the doubled latency of a two-device chain.

// File: rtl/qcfg_pkg.sv
package qcfg_pkg;
   typedef enum logic [1:0] {
      KIND_MODE  = 2'd0,
      KIND_START = 2'd1,
      KIND_END   = 2'd2
   } reg_kind_e;
endpackage

// File: rtl/qcfg_load_ctr.sv
module qcfg_load_ctr #(
   parameter int NREG  = 9,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sen_in,
   output logic [IDX_W-1:0] idx,
   output logic             load_en,
   output logic             done
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NREG - 1);

   // one setup register per edge, only while upstream reports done (low)
   assign load_en = !sen_in && !done;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         idx  <= '0;
         done <= 1'b0;
      end else if (load_en) begin
         if (idx == LAST) done <= 1'b1;
         else             idx  <= idx + 1'b1;
      end
   end
endmodule

// File: rtl/qcfg_addr_calc.sv
module qcfg_addr_calc
   import qcfg_pkg::*;
#(
   parameter int NUM_QUEUES = 4,
   parameter int ADDR_W     = 12,
   parameter int QCNT_W     = 3,
   parameter int IDX_W      = 4,
   parameter int QSEL_W     = 2,
   parameter int QSIZE      = 1024
) (
   input  logic [IDX_W-1:0]  idx,
   output reg_kind_e         kind,
   output logic [QSEL_W-1:0] qsel,
   output logic [ADDR_W-1:0] addr_val,
   output logic [QCNT_W-1:0] mode_val
);
   logic [IDX_W-1:0] idx_m1;
   int               base;

   assign idx_m1   = idx - 1'b1;
   assign mode_val = QCNT_W'(NUM_QUEUES);

   always_comb begin
      qsel = QSEL_W'(idx_m1 >> 1);
      base = int'(qsel) * QSIZE;
      if (idx == '0) begin
         kind     = KIND_MODE;
         addr_val = '0;
      end else if (idx[0]) begin
         kind     = KIND_START;
         addr_val = ADDR_W'(base);
      end else begin
         kind     = KIND_END;
         addr_val = ADDR_W'(base + QSIZE - 1);
      end
   end
endmodule

// File: rtl/qcfg_regfile.sv
module qcfg_regfile
   import qcfg_pkg::*;
#(
   parameter int NUM_QUEUES = 4,
   parameter int ADDR_W     = 12,
   parameter int QCNT_W     = 3,
   parameter int QSEL_W     = 2
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic                             load_en,
   input  reg_kind_e                        kind,
   input  logic [QSEL_W-1:0]                qsel,
   input  logic [ADDR_W-1:0]                addr_val,
   input  logic [QCNT_W-1:0]                mode_val,
   output logic [QCNT_W-1:0]                q_count,
   output logic [NUM_QUEUES-1:0][ADDR_W-1:0] q_start,
   output logic [NUM_QUEUES-1:0][ADDR_W-1:0] q_end
);
   always_ff @(posedge clk or posedge rst) begin
      if (rst)                                q_count <= '0;
      else if (load_en && kind == KIND_MODE)  q_count <= mode_val;
   end

   for (genvar g = 0; g < NUM_QUEUES; g++) begin : g_queue
      logic hit;
      assign hit = load_en && (qsel == QSEL_W'(g));

      always_ff @(posedge clk or posedge rst) begin
         if (rst)                              q_start[g] <= '0;
         else if (hit && kind == KIND_START)   q_start[g] <= addr_val;
      end

      always_ff @(posedge clk or posedge rst) begin
         if (rst)                              q_end[g] <= '0;
         else if (hit && kind == KIND_END)     q_end[g] <= addr_val;
      end
   end
endmodule

// File: rtl/qcfg_default_seq.sv
module qcfg_default_seq
   import qcfg_pkg::*;
#(
   parameter int NUM_QUEUES = 4,
   parameter int MEM_DEPTH  = 4096,
   parameter int ADDR_W     = $clog2(MEM_DEPTH),
   parameter int QCNT_W     = $clog2(NUM_QUEUES + 1)
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic                             sen_in,
   output logic                             sen_out,
   output logic                             cfg_ready,
   output logic [QCNT_W-1:0]                q_count,
   output logic [NUM_QUEUES-1:0][ADDR_W-1:0] q_start,
   output logic [NUM_QUEUES-1:0][ADDR_W-1:0] q_end
);
   localparam int NREG   = 2 * NUM_QUEUES + 1;
   localparam int IDX_W  = $clog2(NREG);
   localparam int QSEL_W = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1;
   localparam int QSIZE  = MEM_DEPTH / NUM_QUEUES;

   if (NUM_QUEUES < 1)                   begin : g_bad_nq    $error("NUM_QUEUES must be at least 1"); end
   if (MEM_DEPTH % NUM_QUEUES != 0)      begin : g_bad_split $error("MEM_DEPTH must divide evenly by NUM_QUEUES"); end
   if ((1 << ADDR_W) < MEM_DEPTH)        begin : g_bad_aw    $error("ADDR_W too narrow for MEM_DEPTH"); end
   if ((1 << QCNT_W) <= NUM_QUEUES)      begin : g_bad_qw    $error("QCNT_W too narrow for NUM_QUEUES"); end

   logic [IDX_W-1:0]  idx;
   logic              load_en;
   logic              done;
   reg_kind_e         kind;
   logic [QSEL_W-1:0] qsel;
   logic [ADDR_W-1:0] addr_val;
   logic [QCNT_W-1:0] mode_val;

   qcfg_load_ctr #(.NREG(NREG), .IDX_W(IDX_W)) u_ctr (
      .clk(clk), .rst(rst), .sen_in(sen_in),
      .idx(idx), .load_en(load_en), .done(done)
   );

   qcfg_addr_calc #(
      .NUM_QUEUES(NUM_QUEUES), .ADDR_W(ADDR_W), .QCNT_W(QCNT_W),
      .IDX_W(IDX_W), .QSEL_W(QSEL_W), .QSIZE(QSIZE)
   ) u_calc (
      .idx(idx), .kind(kind), .qsel(qsel), .addr_val(addr_val), .mode_val(mode_val)
   );

   qcfg_regfile #(
      .NUM_QUEUES(NUM_QUEUES), .ADDR_W(ADDR_W), .QCNT_W(QCNT_W), .QSEL_W(QSEL_W)
   ) u_regs (
      .clk(clk), .rst(rst), .load_en(load_en), .kind(kind), .qsel(qsel),
      .addr_val(addr_val), .mode_val(mode_val),
      .q_count(q_count), .q_start(q_start), .q_end(q_end)
   );

   assign sen_out   = !done;
   assign cfg_ready = done;
endmodule

// File: rtl/qcfg_default_seq_chk.sv
module qcfg_default_seq_chk #(
   parameter int NUM_QUEUES = 4,
   parameter int MEM_DEPTH  = 4096,
   parameter int ADDR_W     = 12,
   parameter int QCNT_W     = 3
) (
   input logic                             clk,
   input logic                             rst,
   input logic                             sen_in,
   input logic                             sen_out,
   input logic                             cfg_ready,
   input logic [QCNT_W-1:0]                q_count,
   input logic [NUM_QUEUES-1:0][ADDR_W-1:0] q_start,
   input logic [NUM_QUEUES-1:0][ADDR_W-1:0] q_end
);
   localparam int QSIZE = MEM_DEPTH / NUM_QUEUES;

   // R1: a reset edge leaves the block idle
   p_reset_idle_r1: assert property (@(posedge clk)
      rst |=> (sen_out && !cfg_ready && q_count == '0));

   // R2: completion only follows an edge with upstream done
   p_fall_needs_sen_r2: assert property (@(posedge clk) disable iff (rst)
      $fell(sen_out) |-> !$past(sen_in));

   // R4: queue count valid once done
   p_count_r4: assert property (@(posedge clk) disable iff (rst)
      !sen_out |-> q_count == QCNT_W'(NUM_QUEUES));

   // R6: waiting freezes everything
   p_wait_frozen_r6: assert property (@(posedge clk) disable iff (rst)
      (sen_in && sen_out) |=> (sen_out && $stable(q_count) && $stable(q_start) && $stable(q_end)));

   // R8: done is permanent until reset
   p_hold_low_r8: assert property (@(posedge clk) disable iff (rst)
      !sen_out |=> (!sen_out && $stable(q_start) && $stable(q_end)));

   // R5: every region has the equal size once done
   for (genvar g = 0; g < NUM_QUEUES; g++) begin : g_size
      p_region_size_r5: assert property (@(posedge clk) disable iff (rst)
         !sen_out |-> (ADDR_W'(q_end[g] - q_start[g]) == ADDR_W'(QSIZE - 1)));
   end
endmodule

bind qcfg_default_seq qcfg_default_seq_chk #(
   .NUM_QUEUES(NUM_QUEUES), .MEM_DEPTH(MEM_DEPTH), .ADDR_W(ADDR_W), .QCNT_W(QCNT_W)
) u_chk (
   .clk(clk), .rst(rst), .sen_in(sen_in), .sen_out(sen_out), .cfg_ready(cfg_ready),
   .q_count(q_count), .q_start(q_start), .q_end(q_end)
);

// File: tb/sim_qcfg_default_seq.sv
module sim_qcfg_default_seq;
   localparam int NQ    = 4;
   localparam int DEPTH = 4096;
   localparam int AW    = 12;
   localparam int QW    = 3;
   localparam int NREG  = 2 * NQ + 1;
   localparam int QS    = DEPTH / NQ;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic sen_in = 1'b0;
   logic s0_out, s1_out, rdy0, rdy1;
   logic [QW-1:0]         cnt0, cnt1;
   logic [NQ-1:0][AW-1:0] st0, en0, st1, en1;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   qcfg_default_seq #(.NUM_QUEUES(NQ), .MEM_DEPTH(DEPTH)) u0 (
      .clk(clk), .rst(rst), .sen_in(sen_in), .sen_out(s0_out), .cfg_ready(rdy0),
      .q_count(cnt0), .q_start(st0), .q_end(en0)
   );

   qcfg_default_seq #(.NUM_QUEUES(NQ), .MEM_DEPTH(DEPTH)) u1 (
      .clk(clk), .rst(rst), .sen_in(s0_out), .sen_out(s1_out), .cfg_ready(rdy1),
      .q_count(cnt1), .q_start(st1), .q_end(en1)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic sen_val);
      @(negedge clk);
      rst = 1'b1;
      sen_in = sen_val;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic wait_fall0(input int limit, output int n);
      n = 0;
      while (s0_out && n < limit) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic check_defaults(input string req);
      chk({req, " count"}, 32'(cnt0), NQ);
      for (int q = 0; q < NQ; q++) begin
         chk({req, " start"}, 32'(st0[q]), q * QS);
         chk({req, " end"}, 32'(en0[q]), (q + 1) * QS - 1);
      end
   endtask

   task automatic t_reset_state;
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk("R1 sen_out", 32'(s0_out), 1);
      chk("R1 ready", 32'(rdy0), 0);
      chk("R1 count", 32'(cnt0), 0);
      chk("R1 start3", 32'(st0[3]), 0);
      chk("R1 end3", 32'(en0[3]), 0);
   endtask

   task automatic t_standalone;
      int n;
      do_reset(1'b0);
      wait_fall0(50, n);
      chk("R2 edges to done", n, NREG);
      chk("R9 ready with low sen_out", 32'(rdy0), 1);
      check_defaults("R4/R5");
   endtask

   task automatic t_hold_after_done;
      sen_in = 1'b1;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         chk("R8 stays low", 32'(s0_out), 0);
      end
      sen_in = 1'b0;
      @(negedge clk);
      chk("R8 ready held", 32'(rdy0), 1);
      check_defaults("R8 values held");
   endtask

   task automatic t_wait_upstream;
      int n;
      do_reset(1'b1);
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (i == 19) begin
            chk("R6 sen_out high", 32'(s0_out), 1);
            chk("R6/R9 ready low", 32'(rdy0), 0);
            chk("R6 count untouched", 32'(cnt0), 0);
            chk("R6 end0 untouched", 32'(en0[0]), 0);
         end
      end
      sen_in = 1'b0;
      wait_fall0(50, n);
      chk("R6 full load after wait", n, NREG);
   endtask

   task automatic t_pause;
      int n;
      do_reset(1'b0);
      repeat (4) @(negedge clk);
      sen_in = 1'b1;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         chk("R7 no done in pause", 32'(s0_out), 1);
      end
      chk("R7 start1 loaded", 32'(st0[1]), QS);
      chk("R7 end1 pending", 32'(en0[1]), 0);
      chk("R7 count loaded first", 32'(cnt0), NQ);
      sen_in = 1'b0;
      wait_fall0(50, n);
      chk("R7 remaining edges", n, NREG - 4);
      check_defaults("R7 after resume");
   endtask

   task automatic t_reset_midway;
      int n;
      do_reset(1'b0);
      repeat (5) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk("R10 cleared count", 32'(cnt0), 0);
      chk("R10 cleared start1", 32'(st0[1]), 0);
      rst = 1'b0;
      wait_fall0(50, n);
      chk("R10 full restart", n, NREG);
   endtask

   task automatic t_chain;
      int n;
      do_reset(1'b0);
      wait_fall0(50, n);
      chk("R3 first stage", n, NREG);
      chk("R3 downstream still busy", 32'(s1_out), 1);
      chk("R3 downstream untouched", 32'(cnt1), 0);
      while (s1_out && n < 100) begin
         @(negedge clk);
         n++;
      end
      chk("R3 chain edges", n, 2 * NREG);
      chk("R3 downstream ready", 32'(rdy1), 1);
      chk("R3 downstream last end", 32'(en1[NQ-1]), DEPTH - 1);
   endtask

   initial begin
      t_reset_state();
      t_standalone();
      t_hold_after_done();
      t_wait_upstream();
      t_pause();
      t_reset_midway();
      t_chain();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule